// File: doc/BRIEF.md
# Bidirectional Line Direction Arbiter

This block joins a host-side serial data line to a card-side serial data line when neither side provides a direction pin. Both lines are open-drain: the block only pulls a line low or releases it. Whichever line falls first becomes the input. The block then pulls the opposite line low so that it follows the input. When the input line goes high again, both sides return to the released, neutral state.

Arbitration runs only while the enable bit is set and the activation logic has enabled reception. Before reception is enabled, the card-side line is held low and the host-side line is left released (high). Each line level is synchronized through a parameterized flip-flop chain before edge detection. A parameter decides which side wins when both lines fall in the same cycle. The two auxiliary channels of an interface would use further instances of the same block.

Top module: `io_dir_arbiter`

## Requirements
- R1: During reset, and while `rx_en_i` is 0, `card_drv_lo` is 1 and `host_drv_lo` is 0.
- R2: With `en_i` and `rx_en_i` both 1 and no falling edge seen since the neutral state, both drive outputs are 0.
- R3: In the neutral state, a host-line falling edge makes `card_drv_lo` 1 and leaves `host_drv_lo` at 0.
- R4: In the neutral state, a card-line falling edge makes `host_drv_lo` 1 and leaves `card_drv_lo` at 0.
- R5: A rising edge on the line that holds the input role returns both drive outputs to 0.
- R6: While one side holds the input role, edges on the driven side do not change either drive output.
- R7: If both lines fall in the same cycle, the host side becomes the input when `HOST_WINS_TIE` is 1, and the card side becomes the input when it is 0.
- R8: Clearing `en_i` sets `host_drv_lo` to 0, and `card_drv_lo` to the value of `!rx_en_i`, in the same cycle. No arbitration occurs while `en_i` is 0, and the block re-enters the neutral state.
- R9: Clearing `rx_en_i` ends any session. The block then holds the card line low and releases the host line.
- R10: `host_drv_lo` and `card_drv_lo` are never 1 together.
- R11: A level change on a line input reaches the drive outputs exactly `SYNC_STAGES`+1 rising clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Arbitration enable bit |
| rx_en_i | input | 1 | Reception enable from the activation logic |
| host_lvl_i | input | 1 | Sampled level of the host-side line (asynchronous) |
| card_lvl_i | input | 1 | Sampled level of the card-side line (asynchronous) |
| host_drv_lo | output | 1 | 1 pulls the host-side line low |
| card_drv_lo | output | 1 | 1 pulls the card-side line low |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and `HOST_WINS_TIE` = 1. The deeper chain makes the latency check meaningful: the outputs must still be unchanged after three clock edges and must change on the fourth. With host priority on ties, simultaneous falls show a clear winner, and that winner differs from what the card-first rule alone would give. Random line, enable and reception changes then drive the state machine through sessions that are interrupted, ignored and overlapping.

// File: rtl/io_arb_pkg.sv
package io_arb_pkg;

   typedef enum logic [1:0] {
      DIR_IDLE    = 2'd0,
      DIR_HOST_IN = 2'd1,
      DIR_CARD_IN = 2'd2
   } dir_state_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned NUM_SIDES       = 2;
   localparam int unsigned SIDE_HOST       = 0;
   localparam int unsigned SIDE_CARD       = 1;

endpackage

// File: rtl/io_line_sync.sv
module io_line_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic fall_o,
   output logic rise_o
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_depth
      $error("io_line_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_LVL}};
         prev_q  <= RESET_LVL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_i};
         prev_q  <= chain_q[LAST];
      end
   end

   assign level_o = chain_q[LAST];
   assign fall_o  = prev_q & ~chain_q[LAST];
   assign rise_o  = ~prev_q & chain_q[LAST];

endmodule

// File: rtl/io_dir_fsm.sv
module io_dir_fsm
   import io_arb_pkg::*;
#(
   parameter bit HOST_WINS_TIE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active_i,
   input  logic       host_fall_i,
   input  logic       host_rise_i,
   input  logic       card_fall_i,
   input  logic       card_rise_i,
   output dir_state_e state_o
);
   dir_state_e state_q, state_d;
   logic       take_host, take_card;

   if (HOST_WINS_TIE) begin : g_host_prio
      assign take_host = host_fall_i;
      assign take_card = card_fall_i & ~host_fall_i;
   end else begin : g_card_prio
      assign take_card = card_fall_i;
      assign take_host = host_fall_i & ~card_fall_i;
   end

   always_comb begin
      state_d = state_q;
      if (!active_i) begin
         state_d = DIR_IDLE;
      end else begin
         unique case (state_q)
            DIR_IDLE: begin
               if (take_host)      state_d = DIR_HOST_IN;
               else if (take_card) state_d = DIR_CARD_IN;
            end
            DIR_HOST_IN: if (host_rise_i) state_d = DIR_IDLE;
            DIR_CARD_IN: if (card_rise_i) state_d = DIR_IDLE;
            default:     state_d = DIR_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= DIR_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   // R6
   host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == DIR_HOST_IN && active_i && !host_rise_i) |=> state_q == DIR_HOST_IN);

   // R6
   card_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == DIR_CARD_IN && active_i && !card_rise_i) |=> state_q == DIR_CARD_IN);

   // R7
   tie_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == DIR_IDLE && active_i && host_fall_i && card_fall_i)
      |=> state_q == (HOST_WINS_TIE ? DIR_HOST_IN : DIR_CARD_IN));

   // R9
   drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> state_q == DIR_IDLE);

endmodule

// File: rtl/io_dir_arbiter.sv
module io_dir_arbiter
   import io_arb_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          HOST_WINS_TIE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic rx_en_i,
   input  logic host_lvl_i,
   input  logic card_lvl_i,
   output logic host_drv_lo,
   output logic card_drv_lo
);
   logic [NUM_SIDES-1:0] raw_lvl, syn_lvl, fall, rise;
   logic                 active;
   dir_state_e           state;

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("io_dir_arbiter: SYNC_STAGES below minimum");
   end

   assign raw_lvl[SIDE_HOST] = host_lvl_i;
   assign raw_lvl[SIDE_CARD] = card_lvl_i;

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      io_line_sync #(
         .STAGES    (SYNC_STAGES),
         .RESET_LVL (1'b1)
      ) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_i  (raw_lvl[s]),
         .level_o (syn_lvl[s]),
         .fall_o  (fall[s]),
         .rise_o  (rise[s])
      );
   end

   assign active = en_i & rx_en_i;

   io_dir_fsm #(
      .HOST_WINS_TIE (HOST_WINS_TIE)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_i    (active),
      .host_fall_i (fall[SIDE_HOST]),
      .host_rise_i (rise[SIDE_HOST]),
      .card_fall_i (fall[SIDE_CARD]),
      .card_rise_i (rise[SIDE_CARD]),
      .state_o     (state)
   );

   assign host_drv_lo = active & (state == DIR_CARD_IN);
   assign card_drv_lo = ~rx_en_i | (active & (state == DIR_HOST_IN));

   // R10
   one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_drv_lo && card_drv_lo));

   // R8
   en_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !host_drv_lo);

   // R9
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en_i |-> (card_drv_lo && !host_drv_lo));

   // R5
   card_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_drv_lo && rise[SIDE_CARD]) |=> !host_drv_lo);

   // R5
   host_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (card_drv_lo && rx_en_i && rise[SIDE_HOST]) |=> !(card_drv_lo && rx_en_i));

   // R3
   host_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_drv_lo && !(card_drv_lo && rx_en_i) && active && fall[SIDE_HOST] && $stable(active))
      |=> (active -> (card_drv_lo && !host_drv_lo)));

   logic unused_lvl;
   assign unused_lvl = ^syn_lvl;

endmodule

// File: tb/sim_io_dir_arbiter.sv
module sim_io_dir_arbiter;
   localparam int unsigned SYNC = 3;
   localparam int unsigned HOLD = 8;
   localparam int unsigned RAND_STEPS = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, rx = 1'b0, hl = 1'b1, cl = 1'b1;
   logic host_drv, card_drv;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // model: 0 neutral, 1 host is input, 2 card is input
   int m_st = 0;
   logic m_ph = 1'b1, m_pc = 1'b1;

   always #2 clk = ~clk;

   io_dir_arbiter #(.SYNC_STAGES(SYNC), .HOST_WINS_TIE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en), .rx_en_i(rx),
      .host_lvl_i(hl), .card_lvl_i(cl),
      .host_drv_lo(host_drv), .card_drv_lo(card_drv));

   function automatic int next_st(int st, logic ph, logic pc, logic h, logic c,
                                  logic e, logic r);
      if (!(e && r)) return 0;
      case (st)
         0: if (ph && !h) return 1; else if (pc && !c) return 2; else return 0;
         1: return (!ph && h) ? 0 : 1;
         2: return (!pc && c) ? 0 : 2;
         default: return 0;
      endcase
   endfunction

   function automatic logic [1:0] exp_out(int st, logic e, logic r);
      logic hd, cd;
      hd = r && e && (st == 2);
      cd = !r || (e && st == 1);
      return {hd, cd};
   endfunction

   task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got host/card=%b expected %b", req, got, exp);
      end
   endtask

   task automatic apply(logic h, logic c, logic e, logic r, string req);
      hl = h; cl = c; en = e; rx = r;
      repeat (HOLD) @(posedge clk);
      @(negedge clk);
      m_st = next_st(m_st, m_ph, m_pc, h, c, e, r);
      m_ph = h; m_pc = c;
      chk(req, {host_drv, card_drv}, exp_out(m_st, e, r));
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1dc0_ffee));
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 in reset", {host_drv, card_drv}, 2'b01);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 after reset rx off", {host_drv, card_drv}, 2'b01);

      apply(1, 1, 1, 1, "R2 idle released");

      // R11 latency: SYNC+1 edges from host fall
      hl = 1'b0;
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      chk("R11 not yet", {host_drv, card_drv}, 2'b00);
      @(posedge clk); @(negedge clk);
      chk("R11 R3 host input", {host_drv, card_drv}, 2'b01);
      m_st = 1; m_ph = 0;

      apply(0, 0, 1, 1, "R6 card low ignored");
      apply(0, 1, 1, 1, "R6 card high ignored");
      apply(1, 1, 1, 1, "R5 host rise releases");
      apply(1, 0, 1, 1, "R4 card input");
      apply(0, 0, 1, 1, "R6 host low ignored");
      apply(1, 0, 1, 1, "R6 host high ignored");
      apply(1, 1, 1, 1, "R5 card rise releases");
      apply(0, 0, 1, 1, "R7 tie host wins");
      apply(1, 1, 1, 1, "R5 release after tie");
      apply(1, 0, 1, 1, "R4 card input again");

      // R8 immediate release when enable cleared
      en = 1'b0;
      #1;
      chk("R8 same cycle release", {host_drv, card_drv}, 2'b00);
      @(negedge clk);
      apply(0, 0, 0, 1, "R8 no arbitration when disabled");
      apply(0, 0, 1, 1, "R8 neutral after re-enable");
      apply(1, 1, 1, 1, "R2 lines idle");
      apply(0, 1, 1, 1, "R3 host input");
      apply(0, 1, 1, 0, "R9 rx off holds card");
      apply(1, 1, 1, 1, "R9 neutral after rx back");

      for (int i = 0; i < RAND_STEPS; i++) begin
         logic h, c, e, r;
         h = 1'($urandom % 2);
         c = 1'($urandom % 2);
         e = ($urandom % 10) != 0;
         r = ($urandom % 10) != 0;
         apply(h, c, e, r, "R10 random session");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule